// File: doc/BRIEF.md
# Normal Interrupt Priority Resolver

This block ranks the normal (non-fast) interrupt sources of a 64-source controller. The surrounding controller hands it a vector of sources that are already pending, enabled and routed to the normal path. The block holds a 4-bit priority for every source in eight 32-bit priority words. Every clock it produces two registered results. The first is a normal request level, gated by a 5-bit mask. The second is a vector-and-status word that names the winning source and carries its priority.

Software programs the priority words through a simple word-offset write port and reads them back through a matching read port. When software consumes the vector word it raises an acknowledge strobe. The block then emits a one-cycle, one-hot clear aimed at the pending bit of the source named in the vector word. The controller uses that pulse to drop the source's pending state. The bus decoder and the fast-interrupt path belong to the enclosing controller.

Top module: `nrm_prio_resolver`

## Requirements
- R1: After reset every priority field reads zero, `irq_o` is 0, `vec_o` is 0xFFFFFFFF and `clr_o` is all zeros.
- R2: The priority of source n sits in priority word n/8, bits 4*(n mod 8)+3 down to 4*(n mod 8). Word k is written and read at word offset 15-k, so offset 8 holds word 7 and offset 15 holds word 0. Writes to offsets 0 to 7 change nothing, and reads there return zero.
- R3: With the mask at 0x1F, `irq_o` is 1 whenever any bit of `pend_i` is set, whatever that source's priority.
- R4: With any other mask value, `irq_o` is 1 only if some set bit of `pend_i` belongs to a source whose priority is strictly greater than the mask.
- R5: The vector word names the pending source with the highest priority. Among sources of equal priority, the higher-numbered source wins.
- R6: The vector word carries the source number in bits 31:16 and its priority in bits 3:0, with all other bits zero. With no bit of `pend_i` set, the word is 0xFFFFFFFF.
- R7: The mask has no effect on the vector word.
- R8: One cycle after an `ack_i` cycle in which `vec_o` names a source, `clr_o` carries a single set bit at that source's position, for that one cycle only. An acknowledge while `vec_o` is 0xFFFFFFFF leaves `clr_o` at zero.
- R9: `irq_o` and `vec_o` reflect `pend_i`, `mask_i` and the priority words as they stood one clock edge earlier. A priority write therefore shows in `vec_o` two edges after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 64 | Pending, enabled, normal-path sources |
| mask_i | input | 5 | Normal request priority mask |
| wr_en_i | input | 1 | Priority word write strobe |
| wr_off_i | input | 4 | Word offset of the write |
| wr_data_i | input | 32 | Write data |
| rd_off_i | input | 4 | Word offset of the read |
| rd_data_o | output | 32 | Priority word at `rd_off_i` (combinational) |
| ack_i | input | 1 | Vector word consumed |
| irq_o | output | 1 | Normal interrupt request |
| vec_o | output | 32 | Vector and status word |
| clr_o | output | 64 | One-hot pending clear pulse |

## Verification
A change on `pend_i` or `mask_i` appears in `irq_o` and `vec_o` after one rising edge. A priority write needs two edges: one to store the word and one to register the new result. A clear appears on `clr_o` one edge after the acknowledge and is gone one edge later. `rd_data_o` follows `rd_off_i` without a clock. The bench changes inputs on the falling edge, then waits the required number of rising edges and samples on the next falling edge. The priority-write case is also sampled after only one edge, to confirm that the old winner is still held at that point.

// File: rtl/nprs_pkg.sv
package nprs_pkg;
  localparam int unsigned NPR_NUM_SRC = 64;
  localparam int unsigned NPR_PRIO_W  = 4;
  localparam int unsigned NPR_MASK_W  = 5;
  localparam int unsigned NPR_WORD_W  = 32;
  localparam int unsigned NPR_SRC_LSB = 16;  // source number field position in vector word
endpackage

// File: rtl/nprs_prio_regs.sv
module nprs_prio_regs #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned PER_WORD  = WORD_W / PRIO_W,
  localparam int unsigned NUM_WORDS = NUM_SRC / PER_WORD,
  localparam int unsigned OFF_W     = $clog2(2 * NUM_WORDS),
  localparam int unsigned OFF_TOP   = 2 * NUM_WORDS - 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [OFF_W-1:0]               wr_off_i,
  input  logic [WORD_W-1:0]              wr_data_i,
  input  logic [OFF_W-1:0]               rd_off_i,
  output logic [WORD_W-1:0]              rd_data_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] word_q;
  logic [OFF_W-1:0] wr_idx, rd_idx;

  // offsets count downward from the top: word k lives at OFF_TOP-k
  assign wr_idx = OFF_W'(OFF_TOP) - wr_off_i;
  assign rd_idx = OFF_W'(OFF_TOP) - rd_off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (wr_en_i && (wr_off_i >= OFF_W'(NUM_WORDS))) begin
      word_q[wr_idx] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_off_i >= OFF_W'(NUM_WORDS)) rd_data_o = word_q[rd_idx];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_unpack
    assign src_prio_o[s] = word_q[s / PER_WORD][PRIO_W*(s % PER_WORD) +: PRIO_W];
  end
endmodule

// File: rtl/nprs_sel_tree.sv
module nprs_sel_tree #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC),
  localparam int unsigned NODES  = 2 * NUM_SRC - 1
) (
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           valid_o,
  output logic [SRC_W-1:0]               src_o,
  output logic [PRIO_W-1:0]              prio_o
);
  // heap-ordered binary tree; leaves NUM_SRC-1 .. NODES-1 hold sources in ascending order
  logic              node_v [NODES];
  logic [SRC_W-1:0]  node_s [NODES];
  logic [PRIO_W-1:0] node_p [NODES];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_leaf
    assign node_v[NUM_SRC-1+s] = pend_i[s];
    assign node_s[NUM_SRC-1+s] = SRC_W'(s);
    assign node_p[NUM_SRC-1+s] = prio_i[s];
  end

  for (genvar n = 0; n < NUM_SRC - 1; n++) begin : g_node
    logic take_hi;
    // upper child covers higher source numbers, so >= hands ties to it
    assign take_hi = node_v[2*n+2] &&
                     (!node_v[2*n+1] || (node_p[2*n+2] >= node_p[2*n+1]));
    assign node_v[n] = node_v[2*n+1] | node_v[2*n+2];
    assign node_s[n] = take_hi ? node_s[2*n+2] : node_s[2*n+1];
    assign node_p[n] = take_hi ? node_p[2*n+2] : node_p[2*n+1];
  end

  assign valid_o = node_v[0];
  assign src_o   = node_s[0];
  assign prio_o  = node_p[0];
endmodule

// File: rtl/nprs_req_gate.sv
module nprs_req_gate #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned MASK_W  = 5
) (
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [MASK_W-1:0]              mask_i,
  output logic                           irq_o
);
  logic [NUM_SRC-1:0] above;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
    assign above[s] = pend_i[s] && (MASK_W'(prio_i[s]) > mask_i);
  end

  // all-ones mask bypasses the priority threshold
  assign irq_o = (mask_i == '1) ? (|pend_i) : (|above);
endmodule

// File: rtl/nrm_prio_resolver.sv
module nrm_prio_resolver
  import nprs_pkg::*;
#(
  parameter int unsigned NUM_SRC = NPR_NUM_SRC,
  parameter int unsigned PRIO_W  = NPR_PRIO_W,
  parameter int unsigned MASK_W  = NPR_MASK_W,
  parameter int unsigned WORD_W  = NPR_WORD_W,
  localparam int unsigned SRC_W     = $clog2(NUM_SRC),
  localparam int unsigned NUM_WORDS = NUM_SRC / (WORD_W / PRIO_W),
  localparam int unsigned OFF_W     = $clog2(2 * NUM_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [MASK_W-1:0]  mask_i,
  input  logic               wr_en_i,
  input  logic [OFF_W-1:0]   wr_off_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [OFF_W-1:0]   rd_off_i,
  output logic [WORD_W-1:0]  rd_data_o,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [WORD_W-1:0]  vec_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio;
  logic              win_v;
  logic [SRC_W-1:0]  win_s;
  logic [PRIO_W-1:0] win_p;
  logic              irq_d, irq_q;
  logic [WORD_W-1:0]  vec_d, vec_q;
  logic [NUM_SRC-1:0] clr_d, clr_q;

  nprs_prio_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .WORD_W(WORD_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_off_i   (wr_off_i),
    .wr_data_i  (wr_data_i),
    .rd_off_i   (rd_off_i),
    .rd_data_o  (rd_data_o),
    .src_prio_o (src_prio)
  );

  nprs_sel_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_tree (
    .pend_i  (pend_i),
    .prio_i  (src_prio),
    .valid_o (win_v),
    .src_o   (win_s),
    .prio_o  (win_p)
  );

  nprs_req_gate #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_gate (
    .pend_i (pend_i),
    .prio_i (src_prio),
    .mask_i (mask_i),
    .irq_o  (irq_d)
  );

  assign vec_d = win_v ? ((WORD_W'(win_s) << NPR_SRC_LSB) | WORD_W'(win_p)) : '1;

  // acknowledge targets the source named by the word software has just seen
  assign clr_d = (ack_i && (vec_q != '1))
               ? (NUM_SRC'(1) << vec_q[NPR_SRC_LSB +: SRC_W]) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '1;
      clr_q <= '0;
    end else begin
      irq_q <= irq_d;
      vec_q <= vec_d;
      clr_q <= clr_d;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
  assign clr_o = clr_q;
endmodule

// File: rtl/nrm_prio_resolver_chk.sv
module nrm_prio_resolver_chk #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned MASK_W  = 5,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [MASK_W-1:0]  mask_i,
  input logic               ack_i,
  input logic               irq_o,
  input logic [WORD_W-1:0]  vec_o,
  input logic [NUM_SRC-1:0] clr_o
);
  assert_clr_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));

  assert_clr_needs_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o != '0) |-> $past(ack_i));

  assert_clr_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (vec_o != '1)) |=> clr_o[$past(vec_o[16 +: SRC_W])]);

  assert_full_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '1) |=> (irq_o == $past(|pend_i)));

  assert_idle_no_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |=> !irq_o);

  assert_idle_vec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |=> (vec_o == '1));

  assert_busy_vec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i != '0) |=> (vec_o != '1));
endmodule

bind nrm_prio_resolver nrm_prio_resolver_chk #(
  .NUM_SRC(NUM_SRC), .MASK_W(MASK_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pend_i (pend_i),
  .mask_i (mask_i),
  .ack_i  (ack_i),
  .irq_o  (irq_o),
  .vec_o  (vec_o),
  .clr_o  (clr_o)
);

// File: tb/nrm_prio_resolver_bench.sv
`timescale 1ns/1ps
module nrm_prio_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pend = '0;
  logic [4:0]  mask = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_off = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_off = '0;
  logic [31:0] rd_data;
  logic        ack = 1'b0;
  logic        irq;
  logic [31:0] vec;
  logic [63:0] clr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nrm_prio_resolver u_nrm_prio_resolver (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .mask_i(mask),
    .wr_en_i(wr_en), .wr_off_i(wr_off), .wr_data_i(wr_data),
    .rd_off_i(rd_off), .rd_data_o(rd_data), .ack_i(ack),
    .irq_o(irq), .vec_o(vec), .clr_o(clr)
  );

  typedef struct packed {
    logic [63:0] pend;
    logic [4:0]  mask;
    logic        irq;
    logic [31:0] vec;
  } vec_t;

  // priorities: src0=1, src5=3, src12=15, src40=9, src63=9, all others 0
  localparam vec_t TBL [13] = '{
    '{64'h0,                  5'h00, 1'b0, 32'hFFFF_FFFF},
    '{64'h20,                 5'h1F, 1'b1, 32'h0005_0003},
    '{64'h20,                 5'h03, 1'b0, 32'h0005_0003},
    '{64'h20,                 5'h02, 1'b1, 32'h0005_0003},
    '{64'h8000_0100_0000_0000, 5'h08, 1'b1, 32'h003F_0009},
    '{64'h8000_0100_0000_0000, 5'h09, 1'b0, 32'h003F_0009},
    '{64'h0000_0100_0000_1020, 5'h00, 1'b1, 32'h000C_000F},
    '{64'h2,                  5'h1F, 1'b1, 32'h0001_0000},
    '{64'h2,                  5'h00, 1'b0, 32'h0001_0000},
    '{64'h1000,               5'h10, 1'b0, 32'h000C_000F},
    '{64'h3,                  5'h00, 1'b1, 32'h0000_0001},
    '{64'hFFFF_FFFF_FFFF_FFFF, 5'h1E, 1'b0, 32'h000C_000F},
    '{64'hC,                  5'h1F, 1'b1, 32'h0003_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_word(input logic [3:0] off, input logic [31:0] data);
    wr_en = 1'b1; wr_off = off; wr_data = data;
    cyc();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 vec", 64'(vec), 64'hFFFF_FFFF);
    chk("R1 clr", clr, 64'h0);
    rd_off = 4'd15; #0.5;
    chk("R1 prio word 0", 64'(rd_data), 64'h0);
    rst_n = 1'b1;
    cyc();

    // R2: program priorities, word k at offset 15-k
    wr_word(4'd15, 32'h0030_0001);
    wr_word(4'd14, 32'h000F_0000);
    wr_word(4'd10, 32'h0000_0009);
    wr_word(4'd8,  32'h9000_0000);
    wr_word(4'd3,  32'hFFFF_FFFF);  // low offset: no effect
    rd_off = 4'd15; #0.5; chk("R2 off15", 64'(rd_data), 64'h0030_0001);
    rd_off = 4'd14; #0.5; chk("R2 off14", 64'(rd_data), 64'h000F_0000);
    rd_off = 4'd10; #0.5; chk("R2 off10", 64'(rd_data), 64'h0000_0009);
    rd_off = 4'd8;  #0.5; chk("R2 off8",  64'(rd_data), 64'h9000_0000);
    rd_off = 4'd12; #0.5; chk("R2 off12", 64'(rd_data), 64'h0);
    rd_off = 4'd3;  #0.5; chk("R2 off3 ignored", 64'(rd_data), 64'h0);

    // R3 R4 R5 R6 R7: table walk, one edge of latency
    for (int i = 0; i < 13; i++) begin
      pend = TBL[i].pend;
      mask = TBL[i].mask;
      cyc();
      chk($sformatf("R3/R4 irq entry %0d", i), 64'(irq), 64'(TBL[i].irq));
      chk($sformatf("R5/R6/R7 vec entry %0d", i), 64'(vec), 64'(TBL[i].vec));
    end

    // R9: priority write reaches vec two edges later
    pend = 64'h8000_0100_0000_0000; mask = 5'h00;
    cyc();
    chk("R9 before write", 64'(vec), 64'h003F_0009);
    wr_en = 1'b1; wr_off = 4'd8; wr_data = 32'h2000_0000;
    cyc();
    wr_en = 1'b0;
    chk("R9 one edge after write", 64'(vec), 64'h003F_0009);
    cyc();
    chk("R9 two edges after write", 64'(vec), 64'h0028_0009);

    // R8: acknowledge pulse
    chk("R8 idle clr", clr, 64'h0);
    ack = 1'b1;
    cyc();
    ack = 1'b0;
    chk("R8 clr pulse", clr, 64'h0000_0100_0000_0000);
    cyc();
    chk("R8 clr gone", clr, 64'h0);
    pend = '0;
    cyc();
    chk("R6 empty vec", 64'(vec), 64'hFFFF_FFFF);
    ack = 1'b1;
    cyc();
    ack = 1'b0;
    chk("R8 ack on empty", clr, 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule